// File: doc/BRIEF.md
# Sub-Rank Chip Mapper

This block sits in a memory controller whose rank is split into nine sub-ranks. Each sub-rank is one chip with its own chip select and carries 8 bytes of a 72-byte line. The block takes one cache-line access and decides which chips serve it and in what order. The access is described by the position of the line inside its aligned group of eight lines, the number of chips the line occupies, and a read/write flag. The chip count comes from the compressor on writes and from the size predictor on reads. The block returns four things: a 9-bit mask for the column commands, the full ordered chip list, the chip that holds the ECC/metadata word (always the first in the order), and a mask that sends activates and precharges to all nine chips.

A shared policy input selects one of three placements. Under the fixed placement every line climbs from chip 0. Under the alternating placement, odd lines climb and even lines descend. Under the grouped placement, a computed order is used for each of the eight positions in a group. These orders are chosen so that a small line followed by a large line (1+7, 3+5, 5+3, 7+1 chips) never share a chip, and this also holds across group boundaries. A rotation input shifts every chip index modulo 9 so that wear can be spread over time.

Two request lanes are mapped side by side. A registered flag tells the scheduler whether their column masks are disjoint, in which case both can issue together.

Top module: `srm_chip_mapper`

## Requirements
- R1: After synchronous reset every output is zero.
- R2: Results appear exactly one clock after the request is sampled. A lane sampled with valid low shows out_valid, col_mask, act_mask and n_micro all zero on the next cycle.
- R3: A chip count of 1 to 9 uses exactly that many chips. A count of 0 or above 9 is treated as 9. n_micro equals the count that is used.
- R4: Policy code 0 orders the chips 0,1,...,8, before rotation.
- R5: Policy code 1 orders the chips 0..8 ascending for odd line positions and 8..0 descending for even positions, before rotation.
- R6: Policy code 2 gives every position an order that is a permutation of 0..8. Position 0 uses 0..8 ascending. The order depends only on the position within the group of eight.
- R7: Under policy code 2, for every pair of consecutive lines (including position 7 followed by position 0), the first m chips of the earlier line and the first 8-m chips of the later line are disjoint, for m = 1, 3, 5, 7.
- R8: col_mask holds exactly the first n_micro chips of the order. meta_chip equals order entry 0, which sits in bits [3:0]. Entry k sits in bits [4k+3:4k].
- R9: A valid result drives act_mask to all nine ones, and col_write mirrors the request's write flag.
- R10: A rotation r adds r modulo 9 to every chip index, so codes 9..15 act as r-9.
- R11: pair_disjoint is high exactly when both lanes hold valid results whose column masks share no chip.
- R12: Policy code 3 behaves as policy code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Placement: 0 fixed, 1 alternating, 2 grouped, 3 fixed |
| rot | input | 4 | Chip rotation offset, applied modulo 9 |
| a_valid | input | 1 | Lane A request present |
| a_line_pos | input | 3 | Lane A line position in its group of eight |
| a_cnt | input | 4 | Lane A chips needed |
| a_write | input | 1 | Lane A is a write |
| b_valid | input | 1 | Lane B request present |
| b_line_pos | input | 3 | Lane B line position |
| b_cnt | input | 4 | Lane B chips needed |
| b_write | input | 1 | Lane B is a write |
| a_out_valid | output | 1 | Lane A result valid |
| a_col_mask | output | 9 | Lane A column-command chip mask |
| a_act_mask | output | 9 | Lane A activate/precharge mask |
| a_order | output | 36 | Lane A chip order, 4 bits per entry |
| a_meta_chip | output | 4 | Lane A metadata chip |
| a_n_micro | output | 4 | Lane A micro-request count |
| a_col_write | output | 1 | Lane A column command is a write |
| b_out_valid | output | 1 | Lane B result valid |
| b_col_mask | output | 9 | Lane B column-command chip mask |
| b_act_mask | output | 9 | Lane B activate/precharge mask |
| b_order | output | 36 | Lane B chip order |
| b_meta_chip | output | 4 | Lane B metadata chip |
| b_n_micro | output | 4 | Lane B micro-request count |
| b_col_write | output | 1 | Lane B column command is a write |
| pair_disjoint | output | 1 | Both lanes valid with disjoint column masks |

## Verification
Every result, including pair_disjoint, is registered once. A request therefore shows up at the outputs on the first rising edge after it is presented, and the previous result holds until that edge. The bench changes inputs on falling edges and reads the outputs on the next falling edge, which falls exactly one register stage later. One check also reads just before the edge, to confirm that the new request has not yet arrived. The grouped orders are not compared against a copied table. Instead they are checked for their required properties: each is a permutation, the prefix pairs are disjoint across seventeen consecutive lines, they repeat every eight lines, and rotation is consistent with the unrotated order.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int unsigned NCHIP   = 9;
    localparam int unsigned CHIP_W  = 4;
    localparam int unsigned POS_W   = 3;
    localparam int unsigned CNT_W   = 4;
    localparam int unsigned ORDER_W = NCHIP * CHIP_W;

    typedef logic [CHIP_W-1:0] chip_t;
    typedef logic [NCHIP-1:0]  cmask_t;

    typedef enum logic [1:0] {
        POL_FIXED   = 2'd0,
        POL_ALT     = 2'd1,
        POL_GROUPED = 2'd2,
        POL_SPARE   = 2'd3
    } policy_e;

    // A walk around the nine chips: direction and first chip.
    typedef struct packed {
        logic  down;
        chip_t start;
    } walk_t;

    // Grouped placement: ascending walks may shift by one chip against the
    // preceding descending walk and still keep every prefix pair disjoint.
    function automatic walk_t grouped_walk(input logic [POS_W-1:0] pos);
        walk_t w;
        case (pos)
            3'd0:    w = '{down: 1'b0, start: 4'd0};
            3'd1:    w = '{down: 1'b1, start: 4'd8};
            3'd2:    w = '{down: 1'b0, start: 4'd1};
            3'd3:    w = '{down: 1'b1, start: 4'd0};
            3'd4:    w = '{down: 1'b0, start: 4'd1};
            3'd5:    w = '{down: 1'b1, start: 4'd8};
            3'd6:    w = '{down: 1'b0, start: 4'd0};
            default: w = '{down: 1'b1, start: 4'd7};
        endcase
        return w;
    endfunction

    function automatic chip_t add_mod9(input chip_t a, input chip_t b);
        logic [4:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 5'd9) s = s - 5'd9;
        return s[CHIP_W-1:0];
    endfunction

    function automatic chip_t walk_step(input walk_t w, input int unsigned k);
        chip_t off;
        if (w.down) off = (k == 0) ? 4'd0 : 4'(NCHIP - k);
        else        off = 4'(k);
        return add_mod9(w.start, off);
    endfunction

    function automatic cmask_t walk_prefix(input walk_t w, input int unsigned m);
        cmask_t msk;
        msk = '0;
        for (int unsigned k = 0; k < NCHIP; k++)
            if (k < m) msk[walk_step(w, k)] = 1'b1;
        return msk;
    endfunction

endpackage

// File: rtl/srm_order_gen.sv
module srm_order_gen
    import srm_pkg::*;
(
    input  logic [1:0]         policy,
    input  logic [POS_W-1:0]   line_pos,
    input  logic [CHIP_W-1:0]  rot,
    output logic [ORDER_W-1:0] order_flat
);

    walk_t w;
    chip_t rot_eff;

    always_comb begin
        rot_eff = (rot >= 4'(NCHIP)) ? rot - 4'(NCHIP) : rot;
        case (policy_e'(policy))
            POL_ALT:     w = line_pos[0] ? '{down: 1'b0, start: 4'd0}
                                         : '{down: 1'b1, start: 4'd8};
            POL_GROUPED: w = grouped_walk(line_pos);
            default:     w = '{down: 1'b0, start: 4'd0};
        endcase
    end

    for (genvar k = 0; k < NCHIP; k++) begin : g_entry
        assign order_flat[k*CHIP_W +: CHIP_W] = add_mod9(walk_step(w, k), rot_eff);
    end

    // Elaboration-time self-check of the grouped placement table.
    initial begin
        for (int p = 0; p < 8; p++) begin
            AST_PERM_FULL: assert (walk_prefix(grouped_walk(3'(p)), NCHIP) == '1)
                else $error("grouped row %0d is not a permutation", p); // R6
            for (int m = 1; m < 8; m += 2) begin
                AST_PERM_COMPAT: assert ((walk_prefix(grouped_walk(3'(p)), m) &
                        walk_prefix(grouped_walk(3'((p + 1) % 8)), 8 - m)) == '0)
                    else $error("grouped rows %0d/%0d clash at m=%0d", p, (p + 1) % 8, m); // R7
            end
        end
    end

endmodule

// File: rtl/srm_mask_build.sv
module srm_mask_build
    import srm_pkg::*;
(
    input  logic [ORDER_W-1:0] order_flat,
    input  logic [CNT_W-1:0]   cnt,
    output logic [NCHIP-1:0]   mask,
    output logic [CNT_W-1:0]   n_used,
    output logic [CHIP_W-1:0]  first_chip
);

    always_comb begin
        n_used = (cnt == '0 || cnt > CNT_W'(NCHIP)) ? CNT_W'(NCHIP) : cnt;
        mask   = '0;
        for (int unsigned k = 0; k < NCHIP; k++)
            if (k < 32'(n_used)) mask[order_flat[k*CHIP_W +: CHIP_W]] = 1'b1;
        first_chip = order_flat[CHIP_W-1:0];
    end

endmodule

// File: rtl/srm_lane.sv
module srm_lane
    import srm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [POS_W-1:0]   in_pos,
    input  logic [CNT_W-1:0]   in_cnt,
    input  logic               in_write,
    input  logic [1:0]         policy,
    input  logic [CHIP_W-1:0]  rot,
    output logic               out_valid,
    output logic [NCHIP-1:0]   col_mask,
    output logic [NCHIP-1:0]   act_mask,
    output logic [ORDER_W-1:0] order,
    output logic [CHIP_W-1:0]  meta_chip,
    output logic [CNT_W-1:0]   n_micro,
    output logic               col_write,
    output logic [NCHIP-1:0]   next_mask
);

    logic [ORDER_W-1:0] order_c;
    logic [NCHIP-1:0]   mask_c;
    logic [CNT_W-1:0]   n_c;
    logic [CHIP_W-1:0]  first_c;

    srm_order_gen u_gen (
        .policy     (policy),
        .line_pos   (in_pos),
        .rot        (rot),
        .order_flat (order_c)
    );

    srm_mask_build u_mask (
        .order_flat (order_c),
        .cnt        (in_cnt),
        .mask       (mask_c),
        .n_used     (n_c),
        .first_chip (first_c)
    );

    assign next_mask = in_valid ? mask_c : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            col_mask  <= '0;
            act_mask  <= '0;
            order     <= '0;
            meta_chip <= '0;
            n_micro   <= '0;
            col_write <= 1'b0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            col_mask  <= mask_c;
            act_mask  <= '1;
            order     <= order_c;
            meta_chip <= first_c;
            n_micro   <= n_c;
            col_write <= in_write;
        end else begin
            out_valid <= 1'b0;
            col_mask  <= '0;
            act_mask  <= '0;
            n_micro   <= '0;
            col_write <= 1'b0;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && col_mask == '0 && act_mask == '0)); // R2
    AST_CNT_EXACT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cnt != '0 && in_cnt <= CNT_W'(NCHIP))
        |=> ($countones(col_mask) == 32'($past(in_cnt)))); // R3
    AST_CNT_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_cnt == '0 || in_cnt > CNT_W'(NCHIP))) |=> (col_mask == '1)); // R3
    AST_META_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((col_mask >> meta_chip) & 9'd1) != '0)); // R8
    AST_ACT_ALL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (act_mask == '1)); // R9
    AST_WRITE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (col_write == $past(in_write))); // R9

endmodule

// File: rtl/srm_chip_mapper.sv
module srm_chip_mapper
    import srm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          policy,
    input  logic [3:0]          rot,
    input  logic                a_valid,
    input  logic [2:0]          a_line_pos,
    input  logic [3:0]          a_cnt,
    input  logic                a_write,
    input  logic                b_valid,
    input  logic [2:0]          b_line_pos,
    input  logic [3:0]          b_cnt,
    input  logic                b_write,
    output logic                a_out_valid,
    output logic [8:0]          a_col_mask,
    output logic [8:0]          a_act_mask,
    output logic [35:0]         a_order,
    output logic [3:0]          a_meta_chip,
    output logic [3:0]          a_n_micro,
    output logic                a_col_write,
    output logic                b_out_valid,
    output logic [8:0]          b_col_mask,
    output logic [8:0]          b_act_mask,
    output logic [35:0]         b_order,
    output logic [3:0]          b_meta_chip,
    output logic [3:0]          b_n_micro,
    output logic                b_col_write,
    output logic                pair_disjoint
);

    localparam int unsigned NLANE = 2;

    logic               l_valid [NLANE];
    logic [POS_W-1:0]   l_pos   [NLANE];
    logic [CNT_W-1:0]   l_cnt   [NLANE];
    logic               l_write [NLANE];
    logic               o_valid [NLANE];
    logic [NCHIP-1:0]   o_col   [NLANE];
    logic [NCHIP-1:0]   o_act   [NLANE];
    logic [ORDER_W-1:0] o_order [NLANE];
    logic [CHIP_W-1:0]  o_meta  [NLANE];
    logic [CNT_W-1:0]   o_n     [NLANE];
    logic               o_wr    [NLANE];
    logic [NCHIP-1:0]   nx_mask [NLANE];

    assign l_valid[0] = a_valid;  assign l_valid[1] = b_valid;
    assign l_pos[0]   = a_line_pos; assign l_pos[1] = b_line_pos;
    assign l_cnt[0]   = a_cnt;    assign l_cnt[1]   = b_cnt;
    assign l_write[0] = a_write;  assign l_write[1] = b_write;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        srm_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (l_valid[g]),
            .in_pos    (l_pos[g]),
            .in_cnt    (l_cnt[g]),
            .in_write  (l_write[g]),
            .policy    (policy),
            .rot       (rot),
            .out_valid (o_valid[g]),
            .col_mask  (o_col[g]),
            .act_mask  (o_act[g]),
            .order     (o_order[g]),
            .meta_chip (o_meta[g]),
            .n_micro   (o_n[g]),
            .col_write (o_wr[g]),
            .next_mask (nx_mask[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) pair_disjoint <= 1'b0;
        else     pair_disjoint <= a_valid && b_valid && ((nx_mask[0] & nx_mask[1]) == '0);
    end

    assign a_out_valid = o_valid[0]; assign b_out_valid = o_valid[1];
    assign a_col_mask  = o_col[0];   assign b_col_mask  = o_col[1];
    assign a_act_mask  = o_act[0];   assign b_act_mask  = o_act[1];
    assign a_order     = o_order[0]; assign b_order     = o_order[1];
    assign a_meta_chip = o_meta[0];  assign b_meta_chip = o_meta[1];
    assign a_n_micro   = o_n[0];     assign b_n_micro   = o_n[1];
    assign a_col_write = o_wr[0];    assign b_col_write = o_wr[1];

    AST_DISJ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        pair_disjoint |-> (a_out_valid && b_out_valid)); // R11
    AST_DISJ_NO_SHARE: assert property (@(posedge clk) disable iff (rst)
        pair_disjoint |-> ((a_col_mask & b_col_mask) == '0)); // R11

endmodule

// File: tb/srm_chip_mapper_tb.sv
module srm_chip_mapper_tb;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] policy;
    logic [3:0] rot;
    logic a_valid, b_valid, a_write, b_write;
    logic [2:0] a_line_pos, b_line_pos;
    logic [3:0] a_cnt, b_cnt;
    logic a_out_valid, b_out_valid, a_col_write, b_col_write, pair_disjoint;
    logic [8:0] a_col_mask, b_col_mask, a_act_mask, b_act_mask;
    logic [35:0] a_order, b_order;
    logic [3:0] a_meta_chip, b_meta_chip, a_n_micro, b_n_micro;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    srm_chip_mapper u_dut (
        .clk(clk), .rst(rst), .policy(policy), .rot(rot),
        .a_valid(a_valid), .a_line_pos(a_line_pos), .a_cnt(a_cnt), .a_write(a_write),
        .b_valid(b_valid), .b_line_pos(b_line_pos), .b_cnt(b_cnt), .b_write(b_write),
        .a_out_valid(a_out_valid), .a_col_mask(a_col_mask), .a_act_mask(a_act_mask),
        .a_order(a_order), .a_meta_chip(a_meta_chip), .a_n_micro(a_n_micro),
        .a_col_write(a_col_write),
        .b_out_valid(b_out_valid), .b_col_mask(b_col_mask), .b_act_mask(b_act_mask),
        .b_order(b_order), .b_meta_chip(b_meta_chip), .b_n_micro(b_n_micro),
        .b_col_write(b_col_write),
        .pair_disjoint(pair_disjoint)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] seq_order(input int start, input bit down, input int r);
        logic [35:0] o;
        for (int k = 0; k < 9; k++) begin
            int c;
            c = down ? (start - k + 18) % 9 : (start + k) % 9;
            o[k*4 +: 4] = 4'((c + r) % 9);
        end
        return o;
    endfunction

    function automatic logic [8:0] prefix(input logic [35:0] o, input int m);
        logic [8:0] s;
        s = '0;
        for (int k = 0; k < m; k++) s[o[k*4 +: 4]] = 1'b1;
        return s;
    endfunction

    task automatic set_a(input logic v, input logic [2:0] pos, input logic [3:0] cnt,
                         input logic wr);
        a_valid = v; a_line_pos = pos; a_cnt = cnt; a_write = wr;
    endtask

    task automatic set_b(input logic v, input logic [2:0] pos, input logic [3:0] cnt,
                         input logic wr);
        b_valid = v; b_line_pos = pos; b_cnt = cnt; b_write = wr;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; policy = 2'd0; rot = 4'd0;
        set_a(1'b1, 3'd1, 4'd3, 1'b1); set_b(1'b1, 3'd2, 4'd3, 1'b1);
        repeat (3) step();
        chk("R1 a_out_valid", 64'(a_out_valid), 64'd0);
        chk("R1 a_col_mask", 64'(a_col_mask), 64'd0);
        chk("R1 a_act_mask", 64'(a_act_mask), 64'd0);
        chk("R1 a_order", 64'(a_order), 64'd0);
        chk("R1 b_n_micro", 64'(b_n_micro), 64'd0);
        chk("R1 pair_disjoint", 64'(pair_disjoint), 64'd0);
        set_a(1'b0, 3'd0, 4'd0, 1'b0); set_b(1'b0, 3'd0, 4'd0, 1'b0);
        rst = 1'b0;
        step();
    endtask

    task automatic t_fixed();
        policy = 2'd0; rot = 4'd0;
        set_a(1'b1, 3'd5, 4'd4, 1'b1);
        #5;
        chk("R2 not before edge", 64'(a_out_valid), 64'd0);
        step();
        chk("R2 valid after one edge", 64'(a_out_valid), 64'd1);
        chk("R4 fixed order", 64'(a_order), 64'(seq_order(0, 1'b0, 0)));
        chk("R8 mask four chips", 64'(a_col_mask), 64'h00F);
        chk("R8 meta chip", 64'(a_meta_chip), 64'd0);
        chk("R3 n_micro", 64'(a_n_micro), 64'd4);
        chk("R9 act all", 64'(a_act_mask), 64'h1FF);
        chk("R9 write flag", 64'(a_col_write), 64'd1);
        set_a(1'b0, 3'd0, 4'd0, 1'b0);
        step();
        chk("R2 idle valid", 64'(a_out_valid), 64'd0);
        chk("R2 idle masks", 64'({a_col_mask, a_act_mask, a_n_micro}), 64'd0);
    endtask

    task automatic t_alt();
        policy = 2'd1; rot = 4'd0;
        set_a(1'b1, 3'd3, 4'd3, 1'b0);
        step();
        chk("R5 odd ascending", 64'(a_order), 64'(seq_order(0, 1'b0, 0)));
        chk("R5 odd mask", 64'(a_col_mask), 64'h007);
        chk("R9 read flag", 64'(a_col_write), 64'd0);
        set_a(1'b1, 3'd6, 4'd2, 1'b0);
        step();
        chk("R5 even descending", 64'(a_order), 64'(seq_order(8, 1'b1, 0)));
        chk("R5 even mask", 64'(a_col_mask), 64'h180);
        chk("R8 even meta", 64'(a_meta_chip), 64'd8);
    endtask

    task automatic t_clamp();
        policy = 2'd0; rot = 4'd0;
        set_a(1'b1, 3'd0, 4'd0, 1'b1);
        step();
        chk("R3 zero count n", 64'(a_n_micro), 64'd9);
        chk("R3 zero count mask", 64'(a_col_mask), 64'h1FF);
        set_a(1'b1, 3'd0, 4'd12, 1'b1);
        step();
        chk("R3 over count n", 64'(a_n_micro), 64'd9);
        chk("R3 over count mask", 64'(a_col_mask), 64'h1FF);
        set_a(1'b1, 3'd0, 4'd1, 1'b1);
        step();
        chk("R3 single chip", 64'(a_col_mask), 64'h001);
    endtask

    task automatic t_grouped();
        logic [35:0] ord [17];
        policy = 2'd2; rot = 4'd0;
        for (int l = 0; l < 17; l++) begin
            set_a(1'b1, 3'(l % 8), 4'd9, 1'b0);
            step();
            ord[l] = a_order;
        end
        chk("R6 position 0 ascending", 64'(ord[0]), 64'(seq_order(0, 1'b0, 0)));
        for (int l = 0; l < 8; l++) begin
            chk("R6 permutation", 64'(prefix(ord[l], 9)), 64'h1FF);
            chk("R6 period eight", 64'(ord[l + 8]), 64'(ord[l]));
        end
        for (int l = 0; l < 16; l++)
            for (int m = 1; m < 8; m += 2)
                chk("R7 prefix pair disjoint",
                    64'(prefix(ord[l], m) & prefix(ord[l + 1], 8 - m)), 64'd0);
        set_a(1'b1, 3'd3, 4'd3, 1'b0);
        step();
        chk("R8 grouped mask", 64'(a_col_mask), 64'(prefix(ord[3], 3)));
        chk("R8 grouped meta", 64'(a_meta_chip), 64'(ord[3][3:0]));
    endtask

    task automatic t_rotate();
        logic [35:0] base;
        logic [35:0] exp4;
        policy = 2'd2; rot = 4'd0;
        set_a(1'b1, 3'd3, 4'd9, 1'b0);
        step();
        base = a_order;
        for (int k = 0; k < 9; k++) exp4[k*4 +: 4] = 4'((int'(base[k*4 +: 4]) + 4) % 9);
        rot = 4'd4;
        step();
        chk("R10 rotate by 4", 64'(a_order), 64'(exp4));
        rot = 4'd13;
        step();
        chk("R10 rotate code 13", 64'(a_order), 64'(exp4));
        policy = 2'd0; rot = 4'd8;
        set_a(1'b1, 3'd0, 4'd2, 1'b0);
        step();
        chk("R10 fixed rotate 8 mask", 64'(a_col_mask), 64'h101);
        rot = 4'd0;
    endtask

    task automatic t_spare();
        policy = 2'd3; rot = 4'd0;
        set_a(1'b1, 3'd6, 4'd2, 1'b0);
        step();
        chk("R12 spare code order", 64'(a_order), 64'(seq_order(0, 1'b0, 0)));
        chk("R12 spare code mask", 64'(a_col_mask), 64'h003);
    endtask

    task automatic t_pair();
        policy = 2'd1; rot = 4'd0;
        set_a(1'b1, 3'd1, 4'd4, 1'b0);
        set_b(1'b1, 3'd2, 4'd5, 1'b1);
        step();
        chk("R11 b mask", 64'(b_col_mask), 64'h1F0);
        chk("R11 disjoint pair", 64'(pair_disjoint), 64'd1);
        set_b(1'b1, 3'd2, 4'd6, 1'b1);
        step();
        chk("R11 overlapping pair", 64'(pair_disjoint), 64'd0);
        set_b(1'b0, 3'd2, 4'd1, 1'b1);
        step();
        chk("R11 lane b idle", 64'(pair_disjoint), 64'd0);
        set_a(1'b0, 3'd0, 4'd0, 1'b0);
        step();
    endtask

    initial begin
        set_a(1'b0, 3'd0, 4'd0, 1'b0); set_b(1'b0, 3'd0, 4'd0, 1'b0);
        rst = 1'b1; policy = 2'd0; rot = 4'd0;
        fork
            begin
                step();
                t_reset();
                t_fixed();
                t_alt();
                t_clamp();
                t_grouped();
                t_rotate();
                t_spare();
                t_pair();
            end
            begin
                #(20 * 200000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule